// File: doc/BRIEF.md
# Piecewise-Linear Visible Watermark Blender

This block lays a visible watermark over an 8-bit grayscale host image, one pixel per clock. Each host pixel arrives with its matching watermark pixel and a strength value. The block sorts the host gray level into one of four ranges. It takes that range's slope from a small loadable constant store. It then adds a scaled product of host, slope, strength and watermark back onto the host pixel. The four slopes form a straight-line approximation to a cube-root brightness response. As a result, dark and bright regions receive a perceptually similar amount of overlay.

The slopes and the middle range boundary are programmed through an addressed write/read port. The lowest and highest boundaries are fixed by parameters. All fractional quantities are unsigned with eight fraction bits, so a code of 256 would mean 1.0. Results come out a fixed three cycles after they enter. A synchronous flush can discard everything in flight without touching the stored constants.

Top module: `wm_blend_top`

## Requirements
- R1: While reset is held and after it, the output valid is low and the output pixel is 0. The constant words then read 87, 56, 48 and 44 at addresses 0 to 3, and 128 at address 4.
- R2: A write with cfg_we_i high stores cfg_wdata_i into the word at cfg_addr_i (0 to 4) on the clock edge. cfg_rdata_o always shows the word at cfg_addr_i. Addresses 5 to 7 read as 0, and writes to them change no word.
- R3: The host pixel h selects a slope by priority: word 0 if h <= EDGE_LO (default 63), else word 1 if h <= word 4, else word 2 if h <= EDGE_HI (default 191), else word 3. Every boundary is inclusive.
- R4: With slope k and strength s, the block forms a = floor(k*h/256) and b = floor(s*w/256). It then forms p = floor(a*b/256), and the output is h + p.
- R5: A pixel accepted with pix_valid_i high appears with blend_valid_o high exactly 3 rising edges later. Pixels come out in order, and one may be accepted on every cycle.
- R6: A pixel uses the slope words and strength present on its accepting edge. A constant write on that same edge affects only later pixels.
- R7: flush_i high on an edge drops the pixel offered on that edge and every pixel in flight, so none of them ever shows valid. The constant words are unchanged by the flush.
- R8: When h + p exceeds 255 the output is 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| flush_i | input | 1 | Synchronous pipeline flush |
| pix_valid_i | input | 1 | Host/watermark pair is valid this cycle |
| host_pix_i | input | 8 | Host gray level |
| mark_pix_i | input | 8 | Watermark gray level |
| strength_i | input | 8 | Overlay strength, unsigned fraction of 256 |
| cfg_we_i | input | 1 | Constant store write enable |
| cfg_addr_i | input | 3 | Constant store address |
| cfg_wdata_i | input | 8 | Constant store write data |
| cfg_rdata_o | output | 8 | Constant store read data |
| blend_valid_o | output | 1 | Watermarked pixel valid |
| blend_pix_o | output | 8 | Watermarked pixel |

## Verification
A constant write and a pixel that selects the very word being written can land on the same edge. The bench provokes this by driving a host level in range 0 while it rewrites word 0 in that cycle, then sending the same pixel again on the next cycle. It judges that the first result is computed with the old slope and the second with the new one. The same kind of overlap is exercised between a flush and a freshly offered pixel. The bench expects that pixel and its predecessors to vanish while pixels offered afterwards emerge on schedule.

// File: rtl/wm_blend_pkg.sv
package wm_blend_pkg;

    localparam int PIX_W     = 8;
    localparam int NUM_SEG   = 4;
    localparam int NUM_WORDS = NUM_SEG + 1;
    localparam int ADDR_W    = $clog2(NUM_WORDS);
    localparam int MID_IDX   = NUM_SEG;
    localparam int LATENCY   = 3;

    typedef logic [PIX_W-1:0] pix_t;
    typedef logic [NUM_WORDS-1:0][PIX_W-1:0] words_t;

    // pipeline state: stage 1 products, stage 2 triple product, stage 3 result
    typedef struct packed {
        logic v1;
        pix_t h1;
        pix_t a1;
        pix_t b1;
        logic v2;
        pix_t h2;
        pix_t p2;
        logic v3;
        pix_t o3;
    } pipe_t;

    // unsigned fractional multiply, fraction bits = PIX_W, truncated
    function automatic pix_t frac_mul(input pix_t x, input pix_t y);
        logic [2*PIX_W-1:0] prod;
        prod = x * y;
        return prod[2*PIX_W-1:PIX_W];
    endfunction

    // power-up contents of the constant store
    function automatic pix_t rst_word(input int idx);
        case (idx)
            0:       return 8'd87;
            1:       return 8'd56;
            2:       return 8'd48;
            3:       return 8'd44;
            default: return 8'd128;
        endcase
    endfunction

endpackage

// File: rtl/wm_coef_regs.sv
module wm_coef_regs
    import wm_blend_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  pix_t              wdata_i,
    output pix_t              rdata_o,
    output words_t            words_o
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_WORDS - 1);

    words_t words_d, words_q;

    always_comb begin
        words_d = words_q;
        if (we_i && (addr_i <= LAST_ADDR)) begin
            words_d[addr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                words_q[i] <= rst_word(i);
            end
        end else begin
            words_q <= words_d;
        end
    end

    assign rdata_o = (addr_i <= LAST_ADDR) ? words_q[addr_i] : '0;
    assign words_o = words_q;

    // R2: out-of-range writes leave the store untouched
    assert_oob_write_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (we_i && (addr_i > LAST_ADDR)) |=> $stable(words_q));

    // R2: an in-range write lands at its address
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (we_i && (addr_i <= LAST_ADDR)) |=> (words_q[$past(addr_i)] == $past(wdata_i)));

endmodule

// File: rtl/wm_seg_pick.sv
module wm_seg_pick
    import wm_blend_pkg::*;
#(
    parameter pix_t EDGE_LO = 8'd63,
    parameter pix_t EDGE_HI = 8'd191
) (
    input  pix_t   pix_i,
    input  words_t words_i,
    output pix_t   coef_o
);

    localparam int NUM_BND = NUM_SEG - 1;

    pix_t [NUM_BND-1:0] bound;
    logic [NUM_BND-1:0] at_or_below;

    assign bound[0] = EDGE_LO;
    assign bound[1] = words_i[MID_IDX];
    assign bound[2] = EDGE_HI;

    genvar g;
    generate
        for (g = 0; g < NUM_BND; g++) begin : g_cmp
            assign at_or_below[g] = (pix_i <= bound[g]);
        end
    endgenerate

    // lowest matching boundary wins; none matching selects the top segment
    always_comb begin
        coef_o = words_i[NUM_SEG-1];
        for (int i = NUM_BND - 1; i >= 0; i--) begin
            if (at_or_below[i]) begin
                coef_o = words_i[i];
            end
        end
    end

endmodule

// File: rtl/wm_blend_pipe.sv
module wm_blend_pipe
    import wm_blend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flush_i,
    input  logic valid_i,
    input  pix_t host_i,
    input  pix_t mark_i,
    input  pix_t strength_i,
    input  pix_t coef_i,
    output logic valid_o,
    output pix_t pix_o
);

    pipe_t st_d, st_q;
    logic [PIX_W:0] sum_w;

    always_comb begin
        st_d  = st_q;
        sum_w = {1'b0, st_q.h2} + {1'b0, st_q.p2};

        // stage 1: slope x host, strength x watermark
        st_d.v1 = valid_i & ~flush_i;
        if (valid_i) begin
            st_d.h1 = host_i;
            st_d.a1 = frac_mul(coef_i, host_i);
            st_d.b1 = frac_mul(strength_i, mark_i);
        end

        // stage 2: product of the two partial products
        st_d.v2 = st_q.v1 & ~flush_i;
        if (st_q.v1) begin
            st_d.h2 = st_q.h1;
            st_d.p2 = frac_mul(st_q.a1, st_q.b1);
        end

        // stage 3: saturating add back onto the host level
        st_d.v3 = st_q.v2 & ~flush_i;
        if (st_q.v2) begin
            st_d.o3 = sum_w[PIX_W] ? '1 : sum_w[PIX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.v3;
    assign pix_o   = st_q.o3;

    // R4: a product of two fractions never exceeds either factor
    assert_prod_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q.v1 && !flush_i) |=> (st_q.p2 <= $past(st_q.a1)));

    // R8: the blended result never wraps below the host level
    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q.v2 && !flush_i) |=> (st_q.o3 >= $past(st_q.h2)));

endmodule

// File: rtl/wm_blend_top.sv
module wm_blend_top
    import wm_blend_pkg::*;
#(
    parameter pix_t EDGE_LO = 8'd63,
    parameter pix_t EDGE_HI = 8'd191
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_i,
    input  logic              pix_valid_i,
    input  logic [PIX_W-1:0]  host_pix_i,
    input  logic [PIX_W-1:0]  mark_pix_i,
    input  logic [PIX_W-1:0]  strength_i,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [PIX_W-1:0]  cfg_wdata_i,
    output logic [PIX_W-1:0]  cfg_rdata_o,
    output logic              blend_valid_o,
    output logic [PIX_W-1:0]  blend_pix_o
);

    words_t words;
    pix_t   coef;

    wm_coef_regs u_coef_regs (
        .clk     (clk),
        .rst     (rst),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .rdata_o (cfg_rdata_o),
        .words_o (words)
    );

    wm_seg_pick #(
        .EDGE_LO (EDGE_LO),
        .EDGE_HI (EDGE_HI)
    ) u_seg_pick (
        .pix_i   (host_pix_i),
        .words_i (words),
        .coef_o  (coef)
    );

    wm_blend_pipe u_pipe (
        .clk        (clk),
        .rst        (rst),
        .flush_i    (flush_i),
        .valid_i    (pix_valid_i),
        .host_i     (host_pix_i),
        .mark_i     (mark_pix_i),
        .strength_i (strength_i),
        .coef_i     (coef),
        .valid_o    (blend_valid_o),
        .pix_o      (blend_pix_o)
    );

    // R5: every result traces back to an accepted pixel three edges earlier
    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        blend_valid_o |-> $past(pix_valid_i, LATENCY));

    // R7: no result survives a flush in any of the three preceding edges
    assert_flush_window_R7: assert property (@(posedge clk) disable iff (rst)
        blend_valid_o |-> (!$past(flush_i, 1) && !$past(flush_i, 2) && !$past(flush_i, 3)));

    // R7: the edge after a flush carries no valid result
    assert_flush_clears_R7: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> !blend_valid_o);

endmodule

// File: tb/wm_blend_top_bench.sv
module wm_blend_top_bench;

    localparam int PERIOD = 10;
    localparam int QDEPTH = 4096;
    localparam int E_LO   = 63;
    localparam int E_HI   = 191;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flush_i = 1'b0;
    logic       pix_valid_i = 1'b0;
    logic [7:0] host_pix_i = '0;
    logic [7:0] mark_pix_i = '0;
    logic [7:0] strength_i = '0;
    logic       cfg_we_i = 1'b0;
    logic [2:0] cfg_addr_i = '0;
    logic [7:0] cfg_wdata_i = '0;
    logic [7:0] cfg_rdata_o;
    logic       blend_valid_o;
    logic [7:0] blend_pix_o;

    wm_blend_top u_wm_blend_top (
        .clk           (clk),
        .rst           (rst),
        .flush_i       (flush_i),
        .pix_valid_i   (pix_valid_i),
        .host_pix_i    (host_pix_i),
        .mark_pix_i    (mark_pix_i),
        .strength_i    (strength_i),
        .cfg_we_i      (cfg_we_i),
        .cfg_addr_i    (cfg_addr_i),
        .cfg_wdata_i   (cfg_wdata_i),
        .cfg_rdata_o   (cfg_rdata_o),
        .blend_valid_o (blend_valid_o),
        .blend_pix_o   (blend_pix_o)
    );

    always #(PERIOD/2) clk = ~clk;

    int    cyc = 0;
    int    checks = 0;
    int    errs = 0;
    int    seen = 0;
    int    mdl [0:4];
    int    exp_pix [0:QDEPTH-1];
    int    exp_cyc [0:QDEPTH-1];
    string exp_tag [0:QDEPTH-1];
    int    wr = 0;
    int    rd = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int model_blend(input int h, input int w, input int s);
        int k, a, b, p, r;
        if (h <= E_LO)        k = mdl[0];
        else if (h <= mdl[4]) k = mdl[1];
        else if (h <= E_HI)   k = mdl[2];
        else                  k = mdl[3];
        a = (k * h) / 256;
        b = (s * w) / 256;
        p = (a * b) / 256;
        r = h + p;
        if (r > 255) r = 255;
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        #(PERIOD/4);
    endtask

    // one cycle of stimulus; expected values use the model as it stands
    // before this cycle's write takes effect (R6)
    task automatic run_cycle(input bit v, input int h, input int w, input int s,
                             input bit we, input int addr, input int wd,
                             input bit fl, input string tag);
        tick();
        pix_valid_i = v;
        host_pix_i  = 8'(h);
        mark_pix_i  = 8'(w);
        strength_i  = 8'(s);
        cfg_we_i    = we;
        cfg_addr_i  = 3'(addr);
        cfg_wdata_i = 8'(wd);
        flush_i     = fl;
        if (fl) begin
            while (wr > rd && exp_cyc[wr-1] > cyc) wr--;
        end else if (v) begin
            exp_pix[wr] = model_blend(h, w, s);
            exp_cyc[wr] = cyc + 3;
            exp_tag[wr] = tag;
            wr++;
        end
        if (we && addr < 5) mdl[addr] = wd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) run_cycle(0, 0, 0, 0, 0, 0, 0, 0, "");
    endtask

    task automatic read_chk(input int addr, input int expv, input string req);
        tick();
        pix_valid_i = 1'b0;
        cfg_we_i    = 1'b0;
        flush_i     = 1'b0;
        cfg_addr_i  = 3'(addr);
        #1;
        check(int'(cfg_rdata_o) == expv, req, "constant readback", int'(cfg_rdata_o), expv);
    endtask

    // output scoreboard: value (R4/R3/R8 by tag) and arrival cycle (R5)
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (blend_valid_o) begin
                seen++;
                if (rd == wr) begin
                    check(1'b0, "R7", "unexpected output", int'(blend_pix_o), -1);
                end else begin
                    check(int'(blend_pix_o) == exp_pix[rd], exp_tag[rd], "pixel value",
                          int'(blend_pix_o), exp_pix[rd]);
                    check(cyc == exp_cyc[rd], "R5", "arrival cycle", cyc, exp_cyc[rd]);
                    rd++;
                end
            end else if (rd < wr && exp_cyc[rd] <= cyc) begin
                check(1'b0, "R5", "missing output", cyc, exp_cyc[rd]);
                rd++;
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R5", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        int snap;
        for (int i = 0; i < 5; i++) mdl[i] = (i == 0) ? 87 : (i == 1) ? 56 :
                                             (i == 2) ? 48 : (i == 3) ? 44 : 128;
        repeat (4) tick();
        // R1: outputs quiet under reset
        check(blend_valid_o == 1'b0, "R1", "valid in reset", int'(blend_valid_o), 0);
        check(blend_pix_o == 8'd0, "R1", "pixel in reset", int'(blend_pix_o), 0);
        rst = 1'b0;
        tick();
        check(blend_valid_o == 1'b0, "R1", "valid after reset", int'(blend_valid_o), 0);
        for (int a = 0; a < 5; a++) read_chk(a, mdl[a], "R1");

        // R2: write/readback, then out-of-range writes have no effect
        for (int a = 0; a < 5; a++) run_cycle(0, 0, 0, 0, 1, a, 17 * (a + 3), 0, "");
        for (int a = 0; a < 5; a++) read_chk(a, 17 * (a + 3), "R2");
        for (int a = 5; a < 8; a++) run_cycle(0, 0, 0, 0, 1, a, 8'hEE, 0, "");
        for (int a = 0; a < 8; a++) read_chk(a, (a < 5) ? mdl[a] : 0, "R2");
        run_cycle(0, 0, 0, 0, 1, 0, 87, 0, "");
        run_cycle(0, 0, 0, 0, 1, 1, 56, 0, "");
        run_cycle(0, 0, 0, 0, 1, 2, 48, 0, "");
        run_cycle(0, 0, 0, 0, 1, 3, 44, 0, "");
        run_cycle(0, 0, 0, 0, 1, 4, 128, 0, "");

        // R4/R8/R5: every host level back to back at full strength
        for (int h = 0; h < 256; h++) run_cycle(1, h, h ^ 8'h5A, 255, 0, 0, 0, 0, "R4");
        idle(5);
        // saturation corner: bright host, bright mark, full strength
        run_cycle(1, 250, 255, 255, 0, 0, 0, 0, "R8");
        run_cycle(1, 255, 255, 255, 0, 0, 0, 0, "R8");
        idle(5);

        // R4/R6: host x mark x strength grid with gaps; strength changes per pixel
        for (int h = 0; h < 256; h += 5)
            for (int wi = 0; wi < 6; wi++)
                for (int si = 0; si < 4; si++) begin
                    run_cycle(1, h, wi * 51, si * 85, 0, 0, 0, 0, "R6");
                    if (((h + wi + si) % 7) == 3) idle(1);
                end
        idle(5);

        // R3: distinct slopes expose the inclusive boundaries
        run_cycle(0, 0, 0, 0, 1, 0, 240, 0, "");
        run_cycle(0, 0, 0, 0, 1, 1, 160, 0, "");
        run_cycle(0, 0, 0, 0, 1, 2, 96, 0, "");
        run_cycle(0, 0, 0, 0, 1, 3, 32, 0, "");
        run_cycle(0, 0, 0, 0, 1, 4, 100, 0, "");
        for (int i = 0; i < 8; i++) begin
            int hv;
            hv = (i == 0) ? 63 : (i == 1) ? 64 : (i == 2) ? 100 : (i == 3) ? 101 :
                 (i == 4) ? 191 : (i == 5) ? 192 : (i == 6) ? 0 : 255;
            run_cycle(1, hv, 255, 255, 0, 0, 0, 0, "R3");
        end
        // middle boundary below the low edge: low segment keeps priority
        run_cycle(0, 0, 0, 0, 1, 4, 20, 0, "");
        run_cycle(1, 50, 255, 255, 0, 0, 0, 0, "R3");
        run_cycle(1, 64, 255, 255, 0, 0, 0, 0, "R3");
        idle(5);

        // R6: a write to word 0 on the same edge as a range-0 pixel
        run_cycle(1, 30, 200, 255, 1, 0, 200, 0, "R6");
        run_cycle(1, 30, 200, 255, 0, 0, 0, 0, "R6");
        idle(5);

        // R7: flush drops the offered pixel and all in flight
        snap = seen;
        run_cycle(1, 40, 120, 200, 0, 0, 0, 0, "R7");
        run_cycle(1, 80, 130, 200, 0, 0, 0, 0, "R7");
        run_cycle(1, 120, 140, 200, 0, 0, 0, 1, "R7");
        run_cycle(1, 160, 150, 200, 0, 0, 0, 0, "R7");
        run_cycle(1, 200, 160, 200, 0, 0, 0, 0, "R7");
        idle(6);
        check(seen - snap == 2, "R7", "outputs after flush", seen - snap, 2);
        for (int a = 0; a < 5; a++) read_chk(a, mdl[a], "R7");

        idle(4);
        check(rd == wr, "R5", "pending results drained", wr - rd, 0);
        finish_run();
    end

endmodule